// File: doc/BRIEF.md
# Edge-Strobed Watchdog Timer with Selectable Period

This block watches a processor's strobe line and asks for a system reset when the software stops servicing it. Only a high-to-low transition on the strobe counts as service. A steady level or a rising edge does nothing. The period is measured in cycles of a free-running millisecond tick. A two-bit select chooses one of three periods.

The timer runs only while the system reset is inactive. Each release of the system reset starts a full period from zero. When a period ends without service, the block raises a single-cycle timeout request. The surrounding reset generator turns that request into a long reset pulse. After a request, the block stays silent until the system reset has been asserted and released again.

The strobe passes through a two-flop synchroniser, so it must stay low for at least two clock cycles to be seen. The select input is read only when a period begins.

Top module: `wdt_strobe_watchdog`

## Requirements
- R1: After the asynchronous reset, `timeout` is low. No period runs until the system reset input has been seen inactive.
- R2: The `dly_sel` encoding sets the period in ticks: 2'b00 gives PERIOD_SHORT (150 by default), 2'b01 gives PERIOD_MID (600), and 2'b10 and 2'b11 both give PERIOD_LONG (1200). `timeout` pulses on the clock after the tick that completes the period, and never without a tick in the cycle before.
- R3: A falling edge on `strobe` during a running period clears the count, so a full new period starts. The strobe must stay low for at least two clocks. The edge acts two clocks after the first low sample.
- R4: A rising edge on `strobe`, or a steady high or low level, leaves the running count unchanged.
- R5: While `sys_rst_active` is high, the count stays at zero and `timeout` stays low, whatever the ticks and strobes do. Releasing it starts a full period.
- R6: Every `timeout` pulse is exactly one clock wide.
- R7: After a timeout, no further timeout is raised, and strobes have no effect, until `sys_rst_active` has been asserted and released.
- R8: `dly_sel` is sampled only when a period starts, which is on reset release or on a valid falling edge. A change in the middle of a period does not alter that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ms_tick | input | 1 | One-clock pulse per millisecond time base |
| sys_rst_active | input | 1 | High while the system reset outputs are asserted |
| strobe | input | 1 | Asynchronous service strobe from the processor |
| dly_sel | input | 2 | Period select, read at each period start |
| timeout | output | 1 | One-clock request to force the system reset |

## Verification
Some properties are checked on every cycle by assertions:
- `timeout` is one clock wide and always follows a tick.
- `timeout` is silent while the system reset is active and in the held state after a timeout.
- The count stays below the sampled limit.
- The sampled limit cannot change in the middle of a period.
- The falling-edge detector fires for one cycle only.

Other behaviour only the directed scenarios can show:
- The exact number of ticks to a timeout for each select code.
- That servicing restarts a full period.
- That rising edges and levels are ignored.
- That a select change in the middle of a period is deferred to the next period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        SEL_SHORT    = 2'b00,
        SEL_MID      = 2'b01,
        SEL_LONG     = 2'b10,
        SEL_LONG_ALT = 2'b11
    } dly_sel_e;

endpackage

// File: rtl/wdt_strobe_sync.sv
module wdt_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic fall_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], strobe_i};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign fall_o = sync_q.prev & ~sync_q.chain[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R3

endmodule

// File: rtl/wdt_period_decode.sv
module wdt_period_decode #(
    parameter int PERIOD_SHORT = 150,
    parameter int PERIOD_MID   = 600,
    parameter int PERIOD_LONG  = 1200,
    parameter int CW           = 11
) (
    input  logic [1:0]    sel_i,
    output logic [CW-1:0] limit_o
);
    import wdt_pkg::*;

    always_comb begin
        unique case (dly_sel_e'(sel_i))
            SEL_SHORT:    limit_o = CW'(PERIOD_SHORT);
            SEL_MID:      limit_o = CW'(PERIOD_MID);
            SEL_LONG:     limit_o = CW'(PERIOD_LONG);
            SEL_LONG_ALT: limit_o = CW'(PERIOD_LONG);
            default:      limit_o = CW'(PERIOD_LONG);
        endcase
    end

endmodule

// File: rtl/wdt_strobe_watchdog.sv
module wdt_strobe_watchdog #(
    parameter int PERIOD_SHORT = 150,
    parameter int PERIOD_MID   = 600,
    parameter int PERIOD_LONG  = 1200,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       sys_rst_active,
    input  logic       strobe,
    input  logic [1:0] dly_sel,
    output logic       timeout
);

    localparam int CW = $clog2(PERIOD_LONG + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] limit;
        logic          armed;
        logic          fired;
        logic          req;
    } wd_t;

    wd_t           wd_d, wd_q;
    logic          fall_w;
    logic [CW-1:0] sel_limit_w;

    wdt_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe),
        .fall_o   (fall_w)
    );

    wdt_period_decode #(
        .PERIOD_SHORT (PERIOD_SHORT),
        .PERIOD_MID   (PERIOD_MID),
        .PERIOD_LONG  (PERIOD_LONG),
        .CW           (CW)
    ) u_decode (
        .sel_i   (dly_sel),
        .limit_o (sel_limit_w)
    );

    always_comb begin
        wd_d     = wd_q;
        wd_d.req = 1'b0;
        if (sys_rst_active) begin
            wd_d.cnt   = '0;
            wd_d.armed = 1'b0;
            wd_d.fired = 1'b0;
        end else if (wd_q.fired) begin
            wd_d.cnt = '0;
        end else if (!wd_q.armed) begin
            wd_d.armed = 1'b1;
            wd_d.cnt   = '0;
            wd_d.limit = sel_limit_w;
        end else if (fall_w) begin
            wd_d.cnt   = '0;
            wd_d.limit = sel_limit_w;
        end else if (ms_tick) begin
            if (wd_q.cnt == wd_q.limit - CW'(1)) begin
                wd_d.cnt   = '0;
                wd_d.req   = 1'b1;
                wd_d.fired = 1'b1;
            end else begin
                wd_d.cnt = wd_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_q.cnt   <= '0;
            wd_q.limit <= CW'(PERIOD_LONG);
            wd_q.armed <= 1'b0;
            wd_q.fired <= 1'b0;
            wd_q.req   <= 1'b0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign timeout = wd_q.req;

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout); // R6
    AST_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> $past(ms_tick)); // R2
    AST_QUIET_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_active |=> (!timeout && wd_q.cnt == '0)); // R5
    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wd_q.cnt < wd_q.limit); // R2
    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q.armed && !sys_rst_active && !fall_w) |=> $stable(wd_q.limit)); // R8
    AST_HOLD_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_q.fired && !sys_rst_active) |=> (!timeout && wd_q.cnt == '0)); // R7

endmodule

// File: tb/sim_wdt_strobe_watchdog.sv
`timescale 1ns/1ps
module sim_wdt_strobe_watchdog;

    localparam int PS = 15;
    localparam int PM = 40;
    localparam int PL = 70;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       sys_rst_active = 1'b1;
    logic       strobe = 1'b1;
    logic [1:0] dly_sel = 2'b00;
    logic       timeout;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;
    int run_len  = 0;
    int max_run  = 0;
    int mark     = 0;

    always #2 clk = ~clk;

    wdt_strobe_watchdog #(
        .PERIOD_SHORT (PS),
        .PERIOD_MID   (PM),
        .PERIOD_LONG  (PL),
        .SYNC_STAGES  (2)
    ) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .ms_tick        (ms_tick),
        .sys_rst_active (sys_rst_active),
        .strobe         (strobe),
        .dly_sel        (dly_sel),
        .timeout        (timeout)
    );

    always @(negedge clk) begin
        if (timeout) begin
            if (run_len == 0) pulses++;
            run_len++;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic strobe_fall();
        @(negedge clk) strobe = 1'b0;
        repeat (3) @(negedge clk);
        strobe = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic sys_reset_pulse();
        @(negedge clk) sys_rst_active = 1'b1;
        repeat (3) @(negedge clk);
        sys_rst_active = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 timeout low after reset", int'(timeout), 0);
        ticks(5);
        chk("R1 no period while system reset held", pulses, 0);
    endtask

    task automatic t_period(input logic [1:0] sel, input int p, input string tag);
        dly_sel = sel;
        sys_reset_pulse();
        mark = pulses;
        ticks(p - 1);
        chk({tag, " no timeout one tick early"}, pulses - mark, 0);
        ticks(1);
        chk({tag, " timeout at period end"}, pulses - mark, 1);
    endtask

    task automatic t_service();
        dly_sel = 2'b00;
        sys_reset_pulse();
        mark = pulses;
        ticks(10);
        strobe_fall();
        ticks(10);
        strobe_fall();
        ticks(PS - 1);
        chk("R3 serviced period restarts", pulses - mark, 0);
        ticks(1);
        chk("R3 full period after last service", pulses - mark, 1);
    endtask

    task automatic t_rise_ignored();
        dly_sel = 2'b00;
        @(negedge clk) sys_rst_active = 1'b1;
        strobe = 1'b0;
        repeat (6) @(negedge clk);
        sys_rst_active = 1'b0;
        repeat (3) @(negedge clk);
        mark = pulses;
        ticks(10);
        @(negedge clk) strobe = 1'b1;
        repeat (4) @(negedge clk);
        ticks(PS - 11);
        chk("R4 rising edge and low level do not service", pulses - mark, 0);
        ticks(1);
        chk("R4 timeout counted across rising edge", pulses - mark, 1);
    endtask

    task automatic t_reset_suspend();
        dly_sel = 2'b00;
        @(negedge clk) sys_rst_active = 1'b1;
        mark = pulses;
        ticks(3 * PS);
        strobe_fall();
        chk("R5 no timeout while system reset active", pulses - mark, 0);
        @(negedge clk) sys_rst_active = 1'b0;
        repeat (3) @(negedge clk);
        ticks(PS - 1);
        chk("R5 full period after release", pulses - mark, 0);
        ticks(1);
        chk("R5 timeout after full period", pulses - mark, 1);
    endtask

    task automatic t_hold_after_fire();
        mark = pulses;
        ticks(3 * PS);
        strobe_fall();
        ticks(3 * PS);
        chk("R7 silent after timeout until reset cycle", pulses - mark, 0);
        sys_reset_pulse();
        ticks(PS);
        chk("R7 rearmed after reset cycle", pulses - mark, 1);
    endtask

    task automatic t_sel_midperiod();
        dly_sel = 2'b00;
        sys_reset_pulse();
        mark = pulses;
        ticks(5);
        dly_sel = 2'b10;
        ticks(PS - 6);
        chk("R8 select change mid-period deferred", pulses - mark, 0);
        ticks(1);
        chk("R8 old period kept", pulses - mark, 1);
        dly_sel = 2'b00;
        sys_reset_pulse();
        mark = pulses;
        ticks(5);
        dly_sel = 2'b01;
        strobe_fall();
        ticks(PM - 1);
        chk("R8 new select taken at service", pulses - mark, 0);
        ticks(1);
        chk("R8 service period uses new select", pulses - mark, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_period(2'b00, PS, "R2 sel 00");
        t_period(2'b01, PM, "R2 sel 01");
        t_period(2'b10, PL, "R2 sel 10");
        t_period(2'b11, PL, "R2 sel 11");
        t_service();
        t_rise_ignored();
        t_reset_suspend();
        t_hold_after_fire();
        t_sel_midperiod();
        chk("R6 pulse width one clock", max_run, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule